// File: doc/BRIEF.md
# Synchronized start and frequency-hop controller

This block lines up two kinds of deferred action across four receive channels. One is waking a channel from sleep (start). The other is moving a new oscillator frequency word into the live frequency register (hop). A processor loads a 16-bit hold-off count and a 32-bit shadow frequency word. It tells each channel which of four external sync pins to watch. It then issues a request that names the action (start, hop or both) and the channels concerned.

A request with its sync flag set is a software sync. It enters a fixed delay pipeline and then loads the hold-off counter. A request with the sync flag clear only arms the block. The counter is then loaded by the next rising edge on a pin that at least one requested channel watches. The counter steps down once per clock. When it holds a count of 1, the pending action is applied on the next edge. The fixed delays are chosen so that the total latency is the hold-off value plus 6 clocks for a software sync and plus 3 clocks for a pin sync.

Channels can also be woken at once, with no synchronization, by writing their sleep bits directly. Reset puts every channel to sleep.

Top module: `sync_start_hop_ctrl`

## Requirements
- R1: After reset every sleep bit is 1 (asleep), the live frequency word is 0 and `holdoff_busy` is 0.
- R2: An accepted software-sync start request written at clock edge k, with hold-off value H ≥ 2, clears the sleep bits of exactly the channels set in `ctrl_mask` at edge k+H+6. The bits are unchanged after edge k+H+5.
- R3: For a pin-armed request, a pin first sampled high at edge p (low at p−1) applies the action at edge p+H+3. A pin that is already high when the request is armed does not trigger until it falls and rises again.
- R4: `sel_wdata` bits [2c+1:2c] select the pin that channel c watches. Several channels may share a pin. A rising edge on a pin that no channel in the pending mask watches is ignored.
- R5: A hop request copies the shadow word into `nco_freq` at the same edge a start would fire. `nco_freq` does not change on any other edge. A shadow write in the firing cycle is not seen: the value held before that edge is copied.
- R6: A request with both start and hop set applies both actions on the same edge.
- R7: While the counter runs or a software sync is in flight, further requests are dropped. The pending action fires once, at its original time, and the dropped request never acts.
- R8: A hold-off value of 1 gives a software-sync latency of 7 clocks. A value of 0 behaves as 1.
- R9: A direct sleep write takes effect at its edge (unsynchronized start). If it lands on the firing edge of a start, the requested channels still end up awake.
- R10: `holdoff_busy` is 1 from the edge that accepts a software sync until the firing edge, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_we | input | 1 | Load hold-off count |
| hold_wdata | input | 16 | Hold-off count value |
| freq_we | input | 1 | Load shadow frequency word |
| freq_wdata | input | 32 | Shadow frequency value |
| sel_we | input | 1 | Load per-channel pin choice |
| sel_wdata | input | 8 | Two bits per channel, channel 0 in the low bits |
| sleep_we | input | 1 | Direct sleep write |
| sleep_wdata | input | 4 | Sleep bits, 1 = asleep |
| ctrl_we | input | 1 | Request strobe |
| ctrl_start | input | 1 | Request a start |
| ctrl_hop | input | 1 | Request a hop |
| ctrl_sync | input | 1 | 1 = software sync now, 0 = arm for pin sync |
| ctrl_mask | input | 4 | Channels the request applies to |
| sync_pins | input | 4 | External sync pins, asynchronous |
| chan_sleep | output | 4 | Per-channel sleep state |
| nco_freq | output | 32 | Live oscillator frequency word |
| holdoff_busy | output | 1 | Counter running or software sync in flight |

## Verification
Two functions can land on one clock edge. A start or hop can fire on the same edge as a processor write to the register that the firing action also drives. The bench counts cycles from the request edge and places a direct sleep write and a shadow-frequency write exactly in the cycle before the firing edge. It then judges the result: the requested channels must be awake despite the write, and the live word must equal the shadow value from before that write. It also checks that start and hop requested together change both outputs on one edge, with neither output moving a cycle early.

// File: rtl/ssh_pkg.sv
package ssh_pkg;

  // pending action kinds carried from request to terminal count
  typedef struct packed {
    logic start;
    logic hop;
  } ssh_act_t;

endpackage

// File: rtl/ssh_pin_sync.sv
module ssh_pin_sync #(
  parameter int NUM_PINS     = 4,
  parameter int EXTRA_STAGES = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic [NUM_PINS-1:0] rise_out
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [2:0] meta_q;
    logic [2:0] meta_d;
    logic       rise;

    always_comb begin
      meta_d = {meta_q[1:0], pins_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) meta_q <= '0;
      else        meta_q <= meta_d;
    end

    // rising edge seen on the synchronized copy
    assign rise = meta_q[1] & ~meta_q[2];

    if (EXTRA_STAGES == 0) begin : g_direct
      assign rise_out[g] = rise;
    end else begin : g_pad
      logic [EXTRA_STAGES-1:0] pad_q;
      logic [EXTRA_STAGES-1:0] pad_d;

      always_comb begin
        pad_d    = pad_q << 1;
        pad_d[0] = rise;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pad_q <= '0;
        else        pad_q <= pad_d;
      end

      assign rise_out[g] = pad_q[EXTRA_STAGES-1];
    end
  end

endmodule

// File: rtl/ssh_soft_delay.sv
module ssh_soft_delay #(
  parameter int STAGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic go_out,
  output logic in_flight
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d    = stage_q << 1;
    stage_d[0] = req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign go_out    = stage_q[STAGES-1];
  assign in_flight = |stage_q;

endmodule

// File: rtl/ssh_holdoff.sv
module ssh_holdoff #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_out,
  output logic             fire,
  output logic             running
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? ONE : load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_out = cnt_q;
  assign fire    = (cnt_q == ONE);
  assign running = (cnt_q != '0);

endmodule

// File: rtl/sync_start_hop_ctrl.sv
module sync_start_hop_ctrl
  import ssh_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_PINS = 4,
  parameter int CNT_W    = 16,
  parameter int FREQ_W   = 32,
  parameter int SOFT_LAT = 6,
  parameter int PIN_LAT  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hold_we,
  input  logic [CNT_W-1:0]                    hold_wdata,
  input  logic                                freq_we,
  input  logic [FREQ_W-1:0]                   freq_wdata,
  input  logic                                sel_we,
  input  logic [NUM_CH*$clog2(NUM_PINS)-1:0]  sel_wdata,
  input  logic                                sleep_we,
  input  logic [NUM_CH-1:0]                   sleep_wdata,
  input  logic                                ctrl_we,
  input  logic                                ctrl_start,
  input  logic                                ctrl_hop,
  input  logic                                ctrl_sync,
  input  logic [NUM_CH-1:0]                   ctrl_mask,
  input  logic [NUM_PINS-1:0]                 sync_pins,
  output logic [NUM_CH-1:0]                   chan_sleep,
  output logic [FREQ_W-1:0]                   nco_freq,
  output logic                                holdoff_busy
);

  localparam int SEL_W   = $clog2(NUM_PINS);
  localparam int SEL_TOT = NUM_CH * SEL_W;
  localparam int PIN_PAD = PIN_LAT - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration registers
  logic [CNT_W-1:0]   hold_q,   hold_d;
  logic [FREQ_W-1:0]  shadow_q, shadow_d;
  logic [SEL_TOT-1:0] sel_q,    sel_d;

  always_comb begin
    hold_d   = hold_we  ? hold_wdata : hold_q;
    shadow_d = freq_we  ? freq_wdata : shadow_q;
    sel_d    = sel_we   ? sel_wdata  : sel_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_q   <= '0;
      shadow_q <= '0;
      sel_q    <= '0;
    end else begin
      hold_q   <= hold_d;
      shadow_q <= shadow_d;
      sel_q    <= sel_d;
    end
  end

  // sub-blocks
  logic [NUM_PINS-1:0] pin_rise;
  logic                soft_req;
  logic                soft_go;
  logic                soft_busy;
  logic                pin_load;
  logic                hold_load;
  logic [CNT_W-1:0]    hold_cnt;
  logic                hold_fire;
  logic                hold_run;
  logic                busy;

  ssh_pin_sync #(
    .NUM_PINS     (NUM_PINS),
    .EXTRA_STAGES (PIN_PAD)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pins_in  (sync_pins),
    .rise_out (pin_rise)
  );

  ssh_soft_delay #(
    .STAGES (SOFT_LAT)
  ) u_soft (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_in    (soft_req),
    .go_out    (soft_go),
    .in_flight (soft_busy)
  );

  ssh_holdoff #(
    .CNT_W (CNT_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (hold_load),
    .load_val (hold_q),
    .cnt_out  (hold_cnt),
    .fire     (hold_fire),
    .running  (hold_run)
  );

  assign busy = hold_run | soft_busy;

  // request capture
  ssh_act_t          act_q,   act_d;
  logic [NUM_CH-1:0] mask_q,  mask_d;
  logic              armed_q, armed_d;
  logic              req_take;
  logic              req_real;

  assign req_take = ctrl_we & ~busy;
  assign req_real = req_take & (ctrl_start | ctrl_hop);
  assign soft_req = req_real & ctrl_sync;

  // pins watched by the channels of the pending request
  logic [NUM_PINS-1:0] watched;

  always_comb begin
    watched = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (mask_q[c]) watched[sel_q[c*SEL_W +: SEL_W]] = 1'b1;
    end
  end

  assign pin_load  = armed_q & ~busy & (|(pin_rise & watched));
  assign hold_load = soft_go | pin_load;

  always_comb begin
    act_d   = act_q;
    mask_d  = mask_q;
    armed_d = armed_q;
    if (req_take) begin
      act_d.start = ctrl_start;
      act_d.hop   = ctrl_hop;
      mask_d      = ctrl_mask;
      armed_d     = req_real & ~ctrl_sync;
    end else if (pin_load) begin
      armed_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      mask_q  <= mask_d;
      armed_q <= armed_d;
    end
  end

  // actions at terminal count
  logic [NUM_CH-1:0] sleep_q, sleep_d;
  logic [FREQ_W-1:0] live_q,  live_d;

  always_comb begin
    sleep_d = sleep_we ? sleep_wdata : sleep_q;
    if (hold_fire && act_q.start) sleep_d = sleep_d & ~mask_q;
    live_d = live_q;
    if (hold_fire && act_q.hop) live_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sleep_q <= '1;
      live_q  <= '0;
    end else begin
      sleep_q <= sleep_d;
      live_q  <= live_d;
    end
  end

  assign chan_sleep   = sleep_q;
  assign nco_freq     = live_q;
  assign holdoff_busy = busy;

endmodule

// File: rtl/ssh_checker.sv
module ssh_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_sleep,
  input logic [FREQ_W-1:0] nco_freq,
  input logic              holdoff_busy,
  input logic              sleep_we,
  input logic [CNT_W-1:0]  cnt,
  input logic              fire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (chan_sleep == '1 && nco_freq == '0 && !holdoff_busy));

  p_wake_needs_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~chan_sleep & $past(chan_sleep)) != '0) |-> ($past(sleep_we) || $past(fire)));

  p_freq_moves_at_terminal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_freq != $past(nco_freq)) |-> $past(fire));

  p_no_reload_while_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0) |-> (cnt == $past(cnt) - ONE));

  p_sleep_set_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_sleep & ~$past(chan_sleep)) != '0) |-> $past(sleep_we));

  p_idle_after_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !holdoff_busy);

endmodule

bind sync_start_hop_ctrl ssh_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .FREQ_W (FREQ_W)
) u_ssh_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .chan_sleep   (chan_sleep),
  .nco_freq     (nco_freq),
  .holdoff_busy (holdoff_busy),
  .sleep_we     (sleep_we),
  .cnt          (hold_cnt),
  .fire         (hold_fire)
);

// File: tb/sync_start_hop_ctrl_bench.sv
module sync_start_hop_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold_we, freq_we, sel_we, sleep_we, ctrl_we;
  logic [15:0] hold_wdata;
  logic [31:0] freq_wdata;
  logic [7:0]  sel_wdata;
  logic [3:0]  sleep_wdata;
  logic        ctrl_start, ctrl_hop, ctrl_sync;
  logic [3:0]  ctrl_mask;
  logic [3:0]  sync_pins;
  logic [3:0]  chan_sleep;
  logic [31:0] nco_freq;
  logic        holdoff_busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_start_hop_ctrl u_sync_start_hop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hold_we(hold_we), .hold_wdata(hold_wdata),
    .freq_we(freq_we), .freq_wdata(freq_wdata),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sleep_we(sleep_we), .sleep_wdata(sleep_wdata),
    .ctrl_we(ctrl_we), .ctrl_start(ctrl_start), .ctrl_hop(ctrl_hop),
    .ctrl_sync(ctrl_sync), .ctrl_mask(ctrl_mask),
    .sync_pins(sync_pins),
    .chan_sleep(chan_sleep), .nco_freq(nco_freq), .holdoff_busy(holdoff_busy)
  );

  // {hop[24], start[23], pin_mode[22], pin[21:20], mask[19:16], hold[15:0]}
  localparam logic [31:0] VEC [7] = '{
    32'h008F_0005, 32'h0085_0001, 32'h0082_0000, 32'h0100_0009,
    32'h01E3_0003, 32'h00D8_000C, 32'h018C_012C
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_hold(input logic [15:0] v);
    @(negedge clk); hold_we = 1'b1; hold_wdata = v;
    @(posedge clk); @(negedge clk); hold_we = 1'b0;
  endtask

  task automatic wr_freq(input logic [31:0] v);
    @(negedge clk); freq_we = 1'b1; freq_wdata = v;
    @(posedge clk); @(negedge clk); freq_we = 1'b0;
  endtask

  task automatic wr_sel(input logic [7:0] v);
    @(negedge clk); sel_we = 1'b1; sel_wdata = v;
    @(posedge clk); @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic wr_sleep(input logic [3:0] v);
    @(negedge clk); sleep_we = 1'b1; sleep_wdata = v;
    @(posedge clk); @(negedge clk); sleep_we = 1'b0;
  endtask

  // request strobed at one edge; returns at the following negedge
  task automatic do_ctrl(input logic st, input logic hp, input logic sy, input logic [3:0] m);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_start = st; ctrl_hop = hp; ctrl_sync = sy; ctrl_mask = m;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, sh, cur_f, exp_f;
    logic [3:0]  m, exp_s;
    logic [1:0]  pn;
    logic        pm, st, hp;
    int          h, eff;
    string       tag;

    rst_n = 1'b0;
    hold_we = 0; freq_we = 0; sel_we = 0; sleep_we = 0; ctrl_we = 0;
    hold_wdata = 0; freq_wdata = 0; sel_wdata = 0; sleep_wdata = 0;
    ctrl_start = 0; ctrl_hop = 0; ctrl_sync = 0; ctrl_mask = 0;
    sync_pins = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1", "sleep after reset", 32'(chan_sleep), 32'hF);
    chk("R1", "freq after reset", nco_freq, 32'h0);
    chk("R1", "busy after reset", 32'(holdoff_busy), 32'h0);

    cur_f = 32'h0;

    // table walk
    for (int i = 0; i < 7; i++) begin
      v  = VEC[i];
      h  = int'(v[15:0]);
      eff = (h == 0) ? 1 : h;
      m  = v[19:16];
      pn = v[21:20];
      pm = v[22];
      st = v[23];
      hp = v[24];
      tag = pm ? "R3" : (h <= 1) ? "R8" : (st && hp) ? "R6" : hp ? "R5" : "R2";
      sh = 32'hC0DE_0000 + 32'(i) * 32'h111;
      wr_sleep(4'hF);
      wr_hold(v[15:0]);
      wr_freq(sh);
      if (pm) wr_sel({4{pn}});
      exp_s = st ? (4'hF & ~m) : 4'hF;
      exp_f = hp ? sh : cur_f;
      if (!pm) begin
        do_ctrl(st, hp, 1'b1, m);
        chk("R10", "busy after soft request", 32'(holdoff_busy), 32'h1);
        repeat (eff + 5) @(posedge clk);
        @(negedge clk);
        chk(tag, "sleep one edge early", 32'(chan_sleep), 32'hF);
        chk(tag, "freq one edge early", nco_freq, cur_f);
        @(posedge clk); @(negedge clk);
        chk(tag, "sleep at soft terminal", 32'(chan_sleep), 32'(exp_s));
        chk(tag, "freq at soft terminal", nco_freq, exp_f);
      end else begin
        do_ctrl(st, hp, 1'b0, m);
        sync_pins[pn] = 1'b1;
        @(posedge clk);
        repeat (eff + 2) @(posedge clk);
        @(negedge clk);
        chk(tag, "sleep one edge early", 32'(chan_sleep), 32'hF);
        chk(tag, "freq one edge early", nco_freq, cur_f);
        @(posedge clk); @(negedge clk);
        chk(tag, "sleep at pin terminal", 32'(chan_sleep), 32'(exp_s));
        chk(tag, "freq at pin terminal", nco_freq, exp_f);
        sync_pins = 4'h0;
        repeat (5) @(posedge clk);
        @(negedge clk);
      end
      chk("R10", "busy after terminal", 32'(holdoff_busy), 32'h0);
      cur_f = exp_f;
    end

    // R7 second request while counting is dropped
    wr_sleep(4'hF);
    wr_hold(16'd20);
    do_ctrl(1'b1, 1'b0, 1'b1, 4'b0001);
    repeat (4) @(posedge clk);
    do_ctrl(1'b1, 1'b1, 1'b1, 4'b0010);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R7", "sleep before first terminal", 32'(chan_sleep), 32'hF);
    @(posedge clk); @(negedge clk);
    chk("R7", "only first request fires", 32'(chan_sleep), 32'hE);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R7", "dropped request never acts", 32'(chan_sleep), 32'hE);
    chk("R7", "dropped hop never acts", nco_freq, cur_f);

    // R4 pin selection per channel
    wr_sleep(4'hF);
    wr_hold(16'd2);
    wr_sel(8'b00_00_00_10);
    do_ctrl(1'b1, 1'b0, 1'b0, 4'b0001);
    sync_pins = 4'b1000;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R4", "unwatched pin ignored", 32'(chan_sleep), 32'hF);
    sync_pins = 4'b0000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    sync_pins = 4'b0001;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R4", "pin of unmasked channels ignored", 32'(chan_sleep), 32'hF);
    sync_pins = 4'b0000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    sync_pins = 4'b0100;
    @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R4", "watched pin one edge early", 32'(chan_sleep), 32'hF);
    @(posedge clk); @(negedge clk);
    chk("R4", "watched pin fires", 32'(chan_sleep), 32'hE);
    sync_pins = 4'b0000;

    // R3 a pin already high does not trigger
    wr_sleep(4'hF);
    sync_pins = 4'b0010;
    repeat (5) @(posedge clk);
    wr_sel(8'h55);
    wr_hold(16'd2);
    do_ctrl(1'b1, 1'b0, 1'b0, 4'hF);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R3", "level without edge ignored", 32'(chan_sleep), 32'hF);
    sync_pins = 4'b0000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    sync_pins = 4'b0010;
    @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3", "new edge one edge early", 32'(chan_sleep), 32'hF);
    @(posedge clk); @(negedge clk);
    chk("R3", "new edge fires", 32'(chan_sleep), 32'h0);
    sync_pins = 4'b0000;

    // R9 direct write, and writes colliding with the firing edge
    wr_sleep(4'b0110);
    chk("R9", "direct sleep write", 32'(chan_sleep), 32'h6);
    wr_sleep(4'hF);
    wr_freq(32'h1234_5678);
    wr_hold(16'd4);
    do_ctrl(1'b1, 1'b1, 1'b1, 4'b0011);
    repeat (9) @(posedge clk);
    @(negedge clk);
    sleep_we = 1'b1; sleep_wdata = 4'hF;
    freq_we = 1'b1;  freq_wdata = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    sleep_we = 1'b0; freq_we = 1'b0;
    chk("R9", "fire beats same-cycle sleep write", 32'(chan_sleep), 32'hC);
    chk("R5", "old shadow copied on collision", nco_freq, 32'h1234_5678);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", "live word holds after shadow write", nco_freq, 32'h1234_5678);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule